// File: doc/BRIEF.md
# Disk Bit Deserializer with Sync Detection

This block turns a stream of already-separated disk data bits into 16-bit words. A bit arrives together with a one-cycle valid strobe. It is shifted into the low end of a word-wide shift register, and a framing counter advances. Each time the counter wraps, the register contents go out as a word with its own valid strobe.

After every shift, the whole register is compared with a programmable sync pattern. A match raises a one-cycle interrupt pulse and tags any word emitted on that same bit. When word alignment is enabled in the control register, a match also restarts the framing counter, so the next word boundary falls exactly one word after the pattern. An index pulse from the drive sends a one-cycle pulse to an external interface adapter and also restarts the framing.

The control register drives a bit-cell period select toward the bit clock recovery logic. It also holds precompensation settings and a sync-on-MSB option. These are stored and presented at the ports, but they have no effect inside the block.

Top module: `disk_deser_top`

## Requirements
- R1: After reset, the shift register, framing counter, sync pattern and control fields are zero. Every output is low or zero.
- R2: On each cycle with `bit_vld` high, `bit_val` enters bit 0 of the shift register and the older bits move one place toward bit 15. Cycles with `bit_vld` low change nothing.
- R3: After every shift, the full 16-bit register is compared with the stored sync pattern. On equality, `sync_irq` is high for exactly the following cycle.
- R4: When control bit 10 is 1, a sync match sets the framing counter to zero instead of advancing it. When bit 10 is 0, matches leave the framing untouched.
- R5: Consider the counter value after a bit's update (modulo 16). When it is zero, the next cycle shows `word_vld` high, `word_data` equal to the register contents including that bit, and `word_sync` equal to that bit's match result.
- R6: `cell_fast` follows control bit 8, where 1 selects the 2 us cell (500 kHz) and 0 selects the 4 us cell (250 kHz). It reflects the value in the cycle after the write.
- R7: A cycle with `index_pulse` high gives a one-cycle `flag_pulse` in the next cycle and leaves the framing counter at zero.
- R8: Control bits 14:13 appear on `precomp_len`, bit 12 on `precomp_mfm` and bit 9 on `cfg_msb_sync`. None of them alters shifting, matching or framing.
- R9: When a bit and an index pulse arrive in the same cycle, the bit is shifted and judged for emission and match as usual. The counter then ends at zero because of the index.
- R10: With no valid bit, no word, sync interrupt or counter advance is produced, apart from the counter reset caused by an index pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: a data bit is present |
| bit_val | input | 1 | Data bit value |
| sync_wr | input | 1 | Write strobe for the sync pattern |
| sync_wdata | input | 16 | New sync pattern |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 16 | New control value |
| index_pulse | input | 1 | Index hole seen by the drive |
| word_vld | output | 1 | Strobe: an assembled word is present |
| word_data | output | 16 | Assembled word |
| word_sync | output | 1 | The word's last bit completed a sync match |
| sync_irq | output | 1 | Sync match interrupt pulse |
| flag_pulse | output | 1 | Pulse to the external interface adapter |
| cell_fast | output | 1 | Bit cell select, 1 = 2 us, 0 = 4 us |
| precomp_len | output | 2 | Stored precompensation length |
| precomp_mfm | output | 1 | Stored precompensation type, 1 = MFM |
| cfg_msb_sync | output | 1 | Stored sync-on-MSB option |

## Verification
Two events can land on the framing counter in one cycle: a bit update, which may itself be a sync restart, and an index restart. The bench drives bits and index pulses together at chosen counter phases, both with word alignment on and with it off. A bench model applies the bit first, decides emission and match from that bit, and then zeroes the counter. Every following cycle is then compared against this model, so a wrong priority shows up as a shifted word boundary later in the stream.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int CTRL_W       = 16;
  localparam int CB_CELL_FAST = 8;
  localparam int CB_MSB_SYNC  = 9;
  localparam int CB_WORD_SYNC = 10;
  localparam int CB_PRE_MFM   = 12;
  localparam int CB_PRE_LO    = 13;
  localparam int CB_PRE_HI    = 14;

  typedef struct packed {
    logic [1:0] precomp_len;
    logic       precomp_mfm;
    logic       word_sync_en;
    logic       msb_sync;
    logic       cell_fast;
  } dsk_cfg_t;
endpackage

// File: rtl/dsk_cfg_regs.sv
module dsk_cfg_regs
  import dsk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_wr,
  input  logic [WORD_W-1:0] sync_wdata,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              index_pulse,
  output logic [WORD_W-1:0] sync_word,
  output dsk_cfg_t          cfg,
  output logic              flag_pulse
);
  function automatic dsk_cfg_t decode_ctrl(input logic [CTRL_W-1:0] v);
    dsk_cfg_t c;
    c.precomp_len  = v[CB_PRE_HI:CB_PRE_LO];
    c.precomp_mfm  = v[CB_PRE_MFM];
    c.word_sync_en = v[CB_WORD_SYNC];
    c.msb_sync     = v[CB_MSB_SYNC];
    c.cell_fast    = v[CB_CELL_FAST];
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_word  <= '0;
      cfg        <= '0;
      flag_pulse <= 1'b0;
    end else begin
      if (sync_wr) sync_word <= sync_wdata;
      if (ctrl_wr) cfg <= decode_ctrl(ctrl_wdata);
      flag_pulse <= index_pulse;
    end
  end

  // R6: cell select follows the written bit
  a_r6_cell_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> cfg.cell_fast == $past(ctrl_wdata[CB_CELL_FAST]));
  // R7: index gives a one-cycle flag pulse
  a_r7_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    (index_pulse && !$past(index_pulse)) |=> flag_pulse);
endmodule

// File: rtl/dsk_shifter.sv
module dsk_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [WORD_W-1:0] sync_word,
  output logic [WORD_W-1:0] sreg_q,
  output logic [WORD_W-1:0] sreg_next,
  output logic              match_now
);
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] s, input logic b);
    return {s[WORD_W-2:0], b};
  endfunction

  always_comb begin
    sreg_next = bit_vld ? shift_in(sreg_q, bit_val) : sreg_q;
    match_now = bit_vld && (sreg_next == sync_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_next;
  end

  // R2: new bit lands in bit 0, old bit 0 moves to bit 1
  a_r2_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> (sreg_q[0] == $past(bit_val)) && (sreg_q[1] == $past(sreg_q[0])));
  // R10: register holds without a valid bit
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(sreg_q));
endmodule

// File: rtl/dsk_framer.sv
module dsk_framer #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             match_now,
  input  logic             word_sync_en,
  input  logic             index_pulse,
  output logic             boundary_now,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_upd;
  logic [CNT_W-1:0] cnt_d;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic m, input logic en);
    return (m && en) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    cnt_upd      = bit_vld ? advance(cnt_q, match_now, word_sync_en) : cnt_q;
    boundary_now = bit_vld && (cnt_upd == '0);
    cnt_d        = index_pulse ? '0 : cnt_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7, R9: index leaves the counter at zero
  a_r7_index_clears: assert property (@(posedge clk) disable iff (!rst_n)
    index_pulse |=> cnt_q == '0);
  // R4: aligned match restarts framing
  a_r4_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && match_now && word_sync_en) |=> cnt_q == '0);
  // R10: counter moves only with a bit or index
  a_r10_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !index_pulse) |=> $stable(cnt_q));
endmodule

// File: rtl/disk_deser_top.sv
module disk_deser_top
  import dsk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              sync_wr,
  input  logic [WORD_W-1:0] sync_wdata,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              index_pulse,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              word_sync,
  output logic              sync_irq,
  output logic              flag_pulse,
  output logic              cell_fast,
  output logic [1:0]        precomp_len,
  output logic              precomp_mfm,
  output logic              cfg_msb_sync
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sync_word;
  dsk_cfg_t          cfg;
  logic [WORD_W-1:0] sreg_q, sreg_next;
  logic              match_now;
  logic              boundary_now;
  logic [CNT_W-1:0]  cnt_q;

  dsk_cfg_regs #(.WORD_W(WORD_W)) u_regs (
    .clk, .rst_n, .sync_wr, .sync_wdata, .ctrl_wr, .ctrl_wdata,
    .index_pulse, .sync_word, .cfg, .flag_pulse
  );

  dsk_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk, .rst_n, .bit_vld, .bit_val, .sync_word,
    .sreg_q, .sreg_next, .match_now
  );

  dsk_framer #(.WORD_W(WORD_W)) u_frame (
    .clk, .rst_n, .bit_vld, .match_now,
    .word_sync_en(cfg.word_sync_en), .index_pulse,
    .boundary_now, .cnt_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld  <= 1'b0;
      word_data <= '0;
      word_sync <= 1'b0;
      sync_irq  <= 1'b0;
    end else begin
      word_vld  <= boundary_now;
      word_sync <= boundary_now && match_now;
      sync_irq  <= match_now;
      if (boundary_now) word_data <= sreg_next;
    end
  end

  assign cell_fast    = cfg.cell_fast;
  assign precomp_len  = cfg.precomp_len;
  assign precomp_mfm  = cfg.precomp_mfm;
  assign cfg_msb_sync = cfg.msb_sync;

  // R3: interrupt only after a shifted bit
  a_r3_irq_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |-> $past(bit_vld));
  // R5: a tagged word implies a match pulse in the same cycle
  a_r5_sync_tag: assert property (@(posedge clk) disable iff (!rst_n)
    word_sync |-> (word_vld && sync_irq));
  // R10: no word without a bit
  a_r10_no_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bit_vld));
  // R7: flag follows index
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pulse |-> $past(index_pulse));
  // R5: emitted data carries the last bit in its low position
  a_r5_data_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> word_data[0] == $past(bit_val));
endmodule

// File: tb/disk_deser_top_bench.sv
module disk_deser_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_val = 0, sync_wr = 0, ctrl_wr = 0, index_pulse = 0;
  logic [15:0] sync_wdata = '0, ctrl_wdata = '0;
  logic word_vld, word_sync, sync_irq, flag_pulse, cell_fast, precomp_mfm, cfg_msb_sync;
  logic [15:0] word_data;
  logic [1:0] precomp_len;

  int n_run = 0, n_fail = 0, cycles = 0;

  // model state
  logic [15:0] m_sreg = '0, m_sync = '0, m_word = '0;
  int m_cnt = 0;
  bit m_ws = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  disk_deser_top u_disk_deser_top (
    .clk, .rst_n, .bit_vld, .bit_val, .sync_wr, .sync_wdata, .ctrl_wr, .ctrl_wdata,
    .index_pulse, .word_vld, .word_data, .word_sync, .sync_irq, .flag_pulse,
    .cell_fast, .precomp_len, .precomp_mfm, .cfg_msb_sync
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit b, input bit idx, input string tag);
    bit e_vld, e_match;
    int upd;
    @(negedge clk);
    bit_vld = v; bit_val = b; index_pulse = idx;
    e_vld = 0; e_match = 0; upd = m_cnt;
    if (v) begin
      m_sreg  = {m_sreg[14:0], b};
      e_match = (m_sreg == m_sync);
      upd     = (e_match && m_ws) ? 0 : (m_cnt + 1) % 16;
      e_vld   = (upd == 0);
      if (e_vld) m_word = m_sreg;
    end
    m_cnt = idx ? 0 : upd;
    @(posedge clk); #1;
    bit_vld = 0; bit_val = 0; index_pulse = 0;
    chk(sync_irq == e_match, {tag, " R3 sync_irq"}, 16'(sync_irq), 16'(e_match));
    chk(word_vld == e_vld, {tag, " R5 word_vld"}, 16'(word_vld), 16'(e_vld));
    chk(word_sync == (e_vld && e_match), {tag, " R5 word_sync"}, 16'(word_sync), 16'(e_vld && e_match));
    if (e_vld) chk(word_data == m_word, {tag, " R2 word_data"}, word_data, m_word);
    chk(flag_pulse == idx, {tag, " R7 flag_pulse"}, 16'(flag_pulse), 16'(idx));
  endtask

  task automatic wr_sync(input logic [15:0] v);
    @(negedge clk); sync_wr = 1; sync_wdata = v;
    @(posedge clk); #1; sync_wr = 0; m_sync = v;
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(posedge clk); #1; ctrl_wr = 0; m_ws = v[10];
    chk(cell_fast == v[8], "R6 cell_fast", 16'(cell_fast), 16'(v[8]));
    chk(precomp_len == v[14:13], "R8 precomp_len", 16'(precomp_len), 16'(v[14:13]));
    chk(precomp_mfm == v[12], "R8 precomp_mfm", 16'(precomp_mfm), 16'(v[12]));
    chk(cfg_msb_sync == v[9], "R8 msb_sync", 16'(cfg_msb_sync), 16'(v[9]));
  endtask

  function automatic bit rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic feed_rand(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, rnd_bit(), 0, tag);
  endtask

  task automatic feed_word(input logic [15:0] w, input string tag);
    for (int i = 15; i >= 0; i--) step(1, w[i], 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(word_vld == 0 && sync_irq == 0 && flag_pulse == 0 && word_sync == 0,
        "R1 reset outputs", {12'b0, word_vld, sync_irq, flag_pulse, word_sync}, 16'h0);
    chk(word_data == 0 && cell_fast == 0 && precomp_len == 0 && precomp_mfm == 0 && cfg_msb_sync == 0,
        "R1 reset data/cfg", word_data, 16'h0);
    @(negedge clk); rst_n = 1;

    // R10: idle cycles, zero sync word, nothing happens
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R10 idle");
    // R3 with reset pattern zero: zero bits match immediately
    for (int i = 0; i < 20; i++) step(1, 0, 0, "R1 R3 zero pattern");

    wr_sync(16'h4489);
    wr_ctrl(16'h0000);
    // R4 off: matches at every phase, framing untouched
    for (int p = 0; p < 16; p++) begin
      feed_rand(p + 3, "R4 off");
      feed_word(16'h4489, "R4 off sync");
      step(0, 0, 0, "R10 gap");
    end

    wr_ctrl(16'h0500);  // word sync on, fast cell
    wr_ctrl(16'h0400);  // word sync on, slow cell
    for (int p = 0; p < 16; p++) begin
      feed_rand(p + 5, "R4 on");
      feed_word(16'h4489, "R4 on sync");
      feed_rand(20, "R4 after");
    end

    // R8: stored fields with no framing effect
    wr_ctrl(16'h7700);
    for (int p = 0; p < 8; p++) begin
      feed_rand(p + 7, "R8 stored");
      feed_word(16'h4489, "R8 sync");
    end
    wr_ctrl(16'h2000);

    // R7 index alone at each phase, R9 index with a bit at each phase
    for (int p = 0; p < 16; p++) begin
      feed_rand(p, "R7 pre");
      step(0, 0, 1, "R7 index");
      feed_rand(18, "R7 post");
    end
    for (int ws = 0; ws < 2; ws++) begin
      wr_ctrl(ws ? 16'h0400 : 16'h0000);
      for (int p = 0; p < 16; p++) begin
        feed_rand(p + 1, "R9 pre");
        step(1, rnd_bit(), 1, "R9 bit+index");
        feed_word(16'h4489, "R9 sync");
        step(1, 1, 1, "R9 bit+index2");
        feed_rand(17, "R9 post");
      end
    end

    // sweep of sync patterns
    wr_ctrl(16'h0400);
    for (int k = 0; k < 24; k++) begin
      wr_sync(lfsr ^ 16'(k * 16'h1357));
      feed_word(m_sync, "R3 sweep");
      feed_rand(40, "R5 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule